// File: doc/BRIEF.md
# Two-Wide Register Rename Stage

This block renames a group of up to two decoded instructions every clock cycle. Each instruction carries two architectural source registers and one architectural destination. A speculative mapping table gives the physical register that holds the newest value of each architectural register. A first-in first-out pool of free physical registers supplies a fresh destination for every instruction that is accepted. The renamed group comes out combinationally in the same cycle. It carries the physical sources, the new physical destination, and the mapping that the destination replaced. The downstream reorder logic uses that replaced mapping to free the register later.

The two instructions are renamed together, so the younger one (slot 1) may depend on the older one (slot 0). Equality comparators on the architectural numbers run in parallel with the table read. Where slot 1 reads, or overwrites, the register that slot 0 writes, its result is replaced by slot 0's freshly allocated register. When both slots write the same architectural register, only the younger mapping is stored in the table. Registers that are no longer needed come back through a single release port and join the tail of the pool.

Top module: `rn2_rename`

## Requirements
- R1: An accepted slot 0 takes the physical register at the head of the free pool. An accepted slot 1 takes the next one, or the head itself when slot 0 is not valid. Registers are handed out in the order in which they entered the pool.
- R2: Every source of slot 0 is renamed to the table entry of its architectural register. A slot 1 source that matches no slot 0 destination is also renamed to its table entry.
- R3: When slot 0 is accepted and a slot 1 source equals slot 0's architectural destination, that source is renamed to slot 0's new physical register.
- R4: Renamed outputs appear in the same cycle as the inputs. Table and pool updates made by an accepted group are visible to the group of the next cycle.
- R5: When both slots are accepted with the same architectural destination, the table afterwards holds slot 1's new physical register for that destination.
- R6: The previous mapping reported for a slot is the table entry of its destination. For slot 1, it is slot 0's new physical register when the two destinations are equal and slot 0 is accepted.
- R7: When any slot is valid and fewer than two registers are free, `stall` is high. Both output valids are then low, nothing is taken from the pool and the table is unchanged.
- R8: A slot whose input valid is low takes no register and writes no table entry, and its output valid is low.
- R9: After reset, each architectural register i maps to physical register i. The pool holds registers ARCH_REGS up to PHYS_REGS-1 in ascending order. A register presented on the release port is appended at the pool tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i0_vld | input | 1 | Slot 0 instruction present |
| i0_srca | input | AW | Slot 0 first architectural source |
| i0_srcb | input | AW | Slot 0 second architectural source |
| i0_dst | input | AW | Slot 0 architectural destination |
| i1_vld | input | 1 | Slot 1 instruction present |
| i1_srca | input | AW | Slot 1 first architectural source |
| i1_srcb | input | AW | Slot 1 second architectural source |
| i1_dst | input | AW | Slot 1 architectural destination |
| rel_vld | input | 1 | A physical register is returned this cycle |
| rel_preg | input | PW | Returned physical register |
| stall | output | 1 | Group held back for lack of free registers |
| o0_vld | output | 1 | Slot 0 renamed and accepted |
| o0_psa | output | PW | Slot 0 first physical source |
| o0_psb | output | PW | Slot 0 second physical source |
| o0_pd | output | PW | Slot 0 new physical destination |
| o0_prev | output | PW | Slot 0 replaced mapping |
| o1_vld | output | 1 | Slot 1 renamed and accepted |
| o1_psa | output | PW | Slot 1 first physical source |
| o1_psb | output | PW | Slot 1 second physical source |
| o1_pd | output | PW | Slot 1 new physical destination |
| o1_prev | output | PW | Slot 1 replaced mapping |

## Verification
The assertions assume that the release port only returns registers that are neither mapped nor already free, so the pool can never hold more than PHYS_REGS-ARCH_REGS entries or hand out a duplicate. The stimulus keeps to this by releasing only replaced mappings that the bench has collected from earlier accepted groups, each exactly once. Phases with a narrow range of architectural numbers make same-cycle source and destination matches frequent. A phase with rare releases drains the pool and holds the block in the stall condition.

// File: rtl/rn2_pkg.sv
package rn2_pkg;
   localparam int unsigned GROUP_WIDTH   = 2;
   localparam int unsigned SRCS_PER_INST = 2;
   localparam int unsigned TABLE_READS   = GROUP_WIDTH * (SRCS_PER_INST + 1);
endpackage

// File: rtl/rn2_free_list.sv
module rn2_free_list #(
   parameter int unsigned PHYS_REGS  = 64,
   parameter int unsigned FIRST_FREE = 32,
   localparam int unsigned PW = $clog2(PHYS_REGS),
   localparam int unsigned CW = $clog2(PHYS_REGS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    pop_n,
   input  logic          push,
   input  logic [PW-1:0] push_reg,
   output logic [PW-1:0] head0,
   output logic [PW-1:0] head1,
   output logic [CW-1:0] avail
);
   localparam int unsigned INIT_FREE = PHYS_REGS - FIRST_FREE;

   if ((PHYS_REGS & (PHYS_REGS - 1)) != 0) begin : g_bad_depth
      $error("rn2_free_list: PHYS_REGS must be a power of two");
   end
   if (FIRST_FREE + 2 > PHYS_REGS) begin : g_bad_split
      $error("rn2_free_list: fewer than two initially free registers");
   end

   logic [PW-1:0] pool_q [PHYS_REGS];
   logic [PW-1:0] rd_q, wr_q;
   logic [CW-1:0] cnt_q;

   assign head0 = pool_q[rd_q];
   assign head1 = pool_q[rd_q + PW'(1)];
   assign avail = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < PHYS_REGS; i++)
            pool_q[i] <= (i < INIT_FREE) ? PW'(FIRST_FREE + i) : '0;
         rd_q  <= '0;
         wr_q  <= PW'(INIT_FREE);
         cnt_q <= CW'(INIT_FREE);
      end else begin
         if (push) begin
            pool_q[wr_q] <= push_reg;
            wr_q         <= wr_q + PW'(1);
         end
         rd_q  <= rd_q + PW'(pop_n);
         cnt_q <= cnt_q + CW'(push) - CW'(pop_n);
      end
   end

   a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      CW'(pop_n) <= cnt_q);
   a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(INIT_FREE));
endmodule

// File: rtl/rn2_map_table.sv
module rn2_map_table #(
   parameter int unsigned ARCH_REGS = 32,
   parameter int unsigned PHYS_REGS = 64,
   parameter int unsigned NRD       = 6,
   localparam int unsigned AW = $clog2(ARCH_REGS),
   localparam int unsigned PW = $clog2(PHYS_REGS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NRD-1:0][AW-1:0]  rd_addr,
   output logic [NRD-1:0][PW-1:0]  rd_data,
   input  logic [1:0]              we,
   input  logic [1:0][AW-1:0]      wa,
   input  logic [1:0][PW-1:0]      wd
);
   if ((ARCH_REGS & (ARCH_REGS - 1)) != 0) begin : g_bad_arch
      $error("rn2_map_table: ARCH_REGS must be a power of two");
   end
   if (PHYS_REGS <= ARCH_REGS) begin : g_bad_phys
      $error("rn2_map_table: PHYS_REGS must exceed ARCH_REGS");
   end

   logic [PW-1:0] map_q [ARCH_REGS];

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rd_data[g] = map_q[rd_addr[g]];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
      end else begin
         for (int k = 0; k < 2; k++)
            if (we[k]) map_q[wa[k]] <= wd[k];
      end
   end

   a_r5_one_writer_per_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (we[0] && we[1]) |-> (wa[0] != wa[1]));
endmodule

// File: rtl/rn2_group_fix.sv
module rn2_group_fix #(
   parameter int unsigned AW   = 5,
   parameter int unsigned PW   = 6,
   parameter int unsigned NSRC = 2
) (
   input  logic                   old_ok,
   input  logic                   yng_ok,
   input  logic [AW-1:0]          old_dst,
   input  logic [PW-1:0]          old_new,
   input  logic [NSRC-1:0][AW-1:0] yng_src,
   input  logic [AW-1:0]          yng_dst,
   input  logic [NSRC-1:0][PW-1:0] tbl_src,
   input  logic [PW-1:0]          tbl_prev,
   output logic [NSRC-1:0][PW-1:0] fix_src,
   output logic [PW-1:0]          fix_prev,
   output logic                   old_write
);
   logic dst_hit;

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      logic hit;
      assign hit        = old_ok && (yng_src[g] == old_dst);
      assign fix_src[g] = hit ? old_new : tbl_src[g];
   end

   assign dst_hit   = old_ok && (yng_dst == old_dst);
   assign fix_prev  = dst_hit ? old_new : tbl_prev;
   assign old_write = old_ok && !(yng_ok && dst_hit);
endmodule

// File: rtl/rn2_rename.sv
module rn2_rename #(
   parameter int unsigned ARCH_REGS = 32,
   parameter int unsigned PHYS_REGS = 64,
   localparam int unsigned AW = $clog2(ARCH_REGS),
   localparam int unsigned PW = $clog2(PHYS_REGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          i0_vld,
   input  logic [AW-1:0] i0_srca,
   input  logic [AW-1:0] i0_srcb,
   input  logic [AW-1:0] i0_dst,
   input  logic          i1_vld,
   input  logic [AW-1:0] i1_srca,
   input  logic [AW-1:0] i1_srcb,
   input  logic [AW-1:0] i1_dst,
   input  logic          rel_vld,
   input  logic [PW-1:0] rel_preg,
   output logic          stall,
   output logic          o0_vld,
   output logic [PW-1:0] o0_psa,
   output logic [PW-1:0] o0_psb,
   output logic [PW-1:0] o0_pd,
   output logic [PW-1:0] o0_prev,
   output logic          o1_vld,
   output logic [PW-1:0] o1_psa,
   output logic [PW-1:0] o1_psb,
   output logic [PW-1:0] o1_pd,
   output logic [PW-1:0] o1_prev
);
   import rn2_pkg::*;
   localparam int unsigned CW = $clog2(PHYS_REGS + 1);

   logic [CW-1:0] avail;
   logic [PW-1:0] head0, head1;
   logic [1:0]    pop_n;
   logic          w0_keep;
   logic [TABLE_READS-1:0][AW-1:0] rd_addr;
   logic [TABLE_READS-1:0][PW-1:0] rd_data;
   logic [1:0]          we;
   logic [1:0][AW-1:0]  wa;
   logic [1:0][PW-1:0]  wd;
   logic [SRCS_PER_INST-1:0][PW-1:0] ps1;

   assign stall  = (i0_vld || i1_vld) && (avail < CW'(GROUP_WIDTH));
   assign o0_vld = i0_vld && !stall;
   assign o1_vld = i1_vld && !stall;
   assign pop_n  = {1'b0, o0_vld} + {1'b0, o1_vld};
   assign o0_pd  = head0;
   assign o1_pd  = o0_vld ? head1 : head0;

   rn2_free_list #(.PHYS_REGS(PHYS_REGS), .FIRST_FREE(ARCH_REGS)) u_pool (
      .clk(clk), .rst_n(rst_n), .pop_n(pop_n), .push(rel_vld),
      .push_reg(rel_preg), .head0(head0), .head1(head1), .avail(avail));

   assign rd_addr = {i1_dst, i1_srcb, i1_srca, i0_dst, i0_srcb, i0_srca};
   assign o0_psa  = rd_data[0];
   assign o0_psb  = rd_data[1];
   assign o0_prev = rd_data[2];

   rn2_group_fix #(.AW(AW), .PW(PW), .NSRC(SRCS_PER_INST)) u_fix (
      .old_ok(o0_vld), .yng_ok(o1_vld), .old_dst(i0_dst), .old_new(o0_pd),
      .yng_src({i1_srcb, i1_srca}), .yng_dst(i1_dst),
      .tbl_src({rd_data[4], rd_data[3]}), .tbl_prev(rd_data[5]),
      .fix_src(ps1), .fix_prev(o1_prev), .old_write(w0_keep));

   assign o1_psa = ps1[0];
   assign o1_psb = ps1[1];

   assign we = {o1_vld, w0_keep};
   assign wa = {i1_dst, i0_dst};
   assign wd = {o1_pd, o0_pd};

   rn2_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .NRD(TABLE_READS)) u_map (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
      .we(we), .wa(wa), .wd(wd));

   a_r1_distinct_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      (o0_vld && o1_vld) |-> (o0_pd != o1_pd));
   a_r3_group_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (o0_vld && o1_vld && i1_srca == i0_dst) |-> (o1_psa == o0_pd));
   a_r6_prev_from_elder: assert property (@(posedge clk) disable iff (!rst_n)
      (o0_vld && o1_vld && i1_dst == i0_dst) |-> (o1_prev == o0_pd));
   a_r7_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (!o0_vld && !o1_vld));
   a_r8_idle_no_out: assert property (@(posedge clk) disable iff (!rst_n)
      !i1_vld |-> !o1_vld);
endmodule

// File: tb/rn2_rename_test.sv
module rn2_rename_test;
   localparam int ARCH = 32;
   localparam int PHYS = 64;
   localparam int AW = $clog2(ARCH);
   localparam int PW = $clog2(PHYS);

   logic clk = 1'b0;
   logic rst_n;
   logic i0_vld, i1_vld, rel_vld;
   logic [AW-1:0] i0_srca, i0_srcb, i0_dst, i1_srca, i1_srcb, i1_dst;
   logic [PW-1:0] rel_preg;
   logic stall, o0_vld, o1_vld;
   logic [PW-1:0] o0_psa, o0_psb, o0_pd, o0_prev, o1_psa, o1_psb, o1_pd, o1_prev;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int map_m [ARCH];
   int pool_m [$];
   int retire_m [$];

   always #4 clk = ~clk;

   rn2_rename #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) uut (.*);

   task automatic chk(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic drive(int amax, int v0pct, int v1pct, int relpct);
      i0_vld  = ($urandom_range(0, 99) < v0pct);
      i1_vld  = ($urandom_range(0, 99) < v1pct);
      i0_srca = AW'($urandom_range(0, amax));
      i0_srcb = AW'($urandom_range(0, amax));
      i0_dst  = AW'($urandom_range(0, amax));
      i1_srca = AW'($urandom_range(0, amax));
      i1_srcb = AW'($urandom_range(0, amax));
      i1_dst  = AW'($urandom_range(0, amax));
      rel_vld = 1'b0;
      rel_preg = '0;
      if (retire_m.size() > 0 && $urandom_range(0, 99) < relpct) begin
         rel_vld  = 1'b1;
         rel_preg = PW'(retire_m.pop_front());
      end
   endtask

   // compare one cycle against the behavioural model, then advance the model
   task automatic model_step();
      bit e_stall;
      int p0, p1, e1a, e1b, e1p;
      e_stall = (i0_vld || i1_vld) && (pool_m.size() < 2);
      chk("R7", "stall", int'(stall), int'(e_stall));
      chk("R8", "o0_vld", int'(o0_vld), int'(i0_vld && !e_stall));
      chk("R8", "o1_vld", int'(o1_vld), int'(i1_vld && !e_stall));
      if (!e_stall) begin
         p0 = pool_m[0];
         p1 = i0_vld ? pool_m[1] : pool_m[0];
         if (i0_vld) begin
            chk("R1", "o0_pd", int'(o0_pd), p0);
            chk("R2", "o0_psa", int'(o0_psa), map_m[i0_srca]);
            chk("R2", "o0_psb", int'(o0_psb), map_m[i0_srcb]);
            chk("R6", "o0_prev", int'(o0_prev), map_m[i0_dst]);
         end
         if (i1_vld) begin
            e1a = (i0_vld && i1_srca == i0_dst) ? p0 : map_m[i1_srca];
            e1b = (i0_vld && i1_srcb == i0_dst) ? p0 : map_m[i1_srcb];
            e1p = (i0_vld && i1_dst == i0_dst) ? p0 : map_m[i1_dst];
            chk("R1", "o1_pd", int'(o1_pd), p1);
            chk("R3", "o1_psa", int'(o1_psa), e1a);
            chk("R3", "o1_psb", int'(o1_psb), e1b);
            chk("R6", "o1_prev", int'(o1_prev), e1p);
         end
         if (i0_vld) begin
            retire_m.push_back(map_m[i0_dst]);
            map_m[i0_dst] = p0;
            void'(pool_m.pop_front());
         end
         if (i1_vld) begin
            retire_m.push_back(e1p);
            map_m[i1_dst] = p1;  // R5: younger mapping overwrites
            void'(pool_m.pop_front());
         end
      end
      if (rel_vld) pool_m.push_back(int'(rel_preg));  // R9 tail append
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      i0_vld = 0; i1_vld = 0; rel_vld = 0; rel_preg = '0;
      i0_srca = '0; i0_srcb = '0; i0_dst = '0;
      i1_srca = '0; i1_srcb = '0; i1_dst = '0;
      for (int i = 0; i < ARCH; i++) map_m[i] = i;
      for (int i = ARCH; i < PHYS; i++) pool_m.push_back(i);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "reset idle stall", int'(stall), 0);
      chk("R8", "reset idle o0_vld", int'(o0_vld), 0);

      // directed R9/R4: reset mapping and first allocation
      @(posedge clk); #1;
      i0_vld = 1; i0_srca = 5; i0_srcb = 9; i0_dst = 7;
      i1_vld = 1; i1_srca = 7; i1_srcb = 3; i1_dst = 7;
      @(negedge clk);
      chk("R9", "first pd", int'(o0_pd), ARCH);
      chk("R9", "identity src", int'(o0_psa), 5);
      model_step();
      // R4/R5: next group sees the younger mapping of register 7
      @(posedge clk); #1;
      i0_vld = 1; i0_srca = 7; i0_dst = 2; i1_vld = 0;
      @(negedge clk);
      chk("R5", "younger kept", int'(o0_psa), ARCH + 1);
      model_step();

      for (int c = 0; c < 400; c++) begin
         @(posedge clk); #1 drive(3, 80, 80, 90);
         @(negedge clk); model_step();
      end
      for (int c = 0; c < 400; c++) begin
         @(posedge clk); #1 drive(ARCH - 1, 90, 90, 15);
         @(negedge clk); model_step();
      end
      for (int c = 0; c < 600; c++) begin
         @(posedge clk); #1 drive(7, 50, 60, 70);
         @(negedge clk); model_step();
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule